// File: doc/BRIEF.md
# SPI Master Chip-Select Sequencer

This block is the sequencing core of an SPI master. Software places a data word and a 4-bit peripheral code into a single holding register. The block moves the word into a shift register and runs a mode-0 serial transfer, MSB first. It drives four active-low select lines in one of two ways. In direct mode exactly one line goes low. In decode mode the raw code appears on the lines and an external 1-of-16 decoder turns it into a select. Select lines idle at all ones, so in decode mode the usable addresses are 0 to 14.

Four configuration slots each hold three settings: a clock divider, a delay between consecutive transfers, and a hold bit. In decode mode a code uses slot code[3:2]. In direct mode it uses the slot of the line it selects. A transfer to the same select that is queued before the current one ends continues without releasing the select. With the hold bit set, the select stays low after the last transfer until a different select is requested. In that case the held line rises for one full serial clock period before the new select goes low.

Top module: `spi_cs_seq`

## Requirements
- R1: After reset, and while reset is held, all four select lines are 1, the serial clock is 0 and tx_empty_o is 1.
- R2: In decode mode the select lines carry the 4-bit code unchanged for the whole transfer, and return to 4'b1111 when no peripheral is selected.
- R3: In direct mode, line k goes low when bit k is the lowest zero bit of the code, and the other three lines stay high.
- R4: A write whose effective code is 4'b1111, or a write made while tx_empty_o is 0, is dropped. No transfer results from it and tx_empty_o does not change.
- R5: The configuration slot in use is code[3:2] in decode mode and the index of the selected line in direct mode.
- R6: When fixed_sel_i is 1, the code is taken from fixed_code_i and wr_code_i is ignored.
- R7: tx_empty_o returns to 1 in the same cycle the word moves into the shift register, which is before the serial transfer ends.
- R8: Transfers use mode 0, MSB first. sclk_o stays 0 while no line is selected, each half period lasts divider+1 clocks, and rx_data_o holds the 8 bits sampled from miso_i when rx_done_o pulses.
- R9: If the next word for the same select is accepted before the current transfer ends, the select stays low between the two transfers.
- R10: With the hold bit clear and no queued word, the select lines go to 4'b1111 once the transfer ends.
- R11: With the hold bit set, the select stays low after the transfer with no new data. It also stays low across later transfers to the same select.
- R12: A switch to a different select always passes through 4'b1111. After a held or continuing transfer, this idle time is 2*(divider+1) clocks, measured with the divider of the slot being left.
- R13: The time from the last falling serial edge of a transfer to the first rising edge of a queued transfer is delay+divider+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| decode_en_i | input | 1 | 1: put the code on the lines for an external decoder; 0: direct one-hot select |
| fixed_sel_i | input | 1 | 1: take the code from fixed_code_i instead of wr_code_i |
| fixed_code_i | input | 4 | Fixed peripheral code |
| cfg_div_i | input | 4*DIV_W | Divider per slot, slot k at bits [k*DIV_W +: DIV_W] |
| cfg_dly_i | input | 4*DLY_W | Delay between transfers per slot, slot k at bits [k*DLY_W +: DLY_W] |
| cfg_hold_i | input | 4 | Hold-after-transfer bit per slot |
| wr_valid_i | input | 1 | Write strobe for the holding register |
| wr_code_i | input | 4 | Peripheral code written with the data |
| wr_data_i | input | DATA_W | Transmit word |
| miso_i | input | 1 | Serial data from the slave |
| tx_empty_o | output | 1 | Holding register can accept a word |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| cs_n_o | output | 4 | Select lines, active low |
| rx_data_o | output | DATA_W | Received word |
| rx_done_o | output | 1 | One-cycle pulse at the end of each transfer |

## Verification
The assertions assume two things about the inputs: decode_en_i and the configuration inputs do not change while a select line is low, and mode-fault sensing on line 0 is off whenever a hold bit is set. The bench keeps to both. It changes the mode and the fixed-code source only after it has seen the lines return to 4'b1111. It gives the hold bit only to slot 1, and it never drives reset from outside a directed test. A slave model for each address samples mosi_o on rising sclk_o and answers on miso_i with a byte built from the select pattern it sees. This lets the bench check both data directions and every select pattern without any view of the design's internals.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  localparam int unsigned NUM_CS = 4;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned IDX_W  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_GAP,
    ST_HOLD,
    ST_REL
  } seq_st_e;
endpackage

// File: rtl/spi_cs_map.sv
module spi_cs_map
  import spi_cs_pkg::*;
(
  input  logic              decode_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              valid_o
);
  logic found;

  always_comb begin
    cs_n_o  = '1;
    idx_o   = '0;
    found   = 1'b0;
    valid_o = (code_i != '1);
    if (decode_i) begin
      cs_n_o = code_i;
      idx_o  = code_i[CODE_W-1 -: IDX_W];
    end else begin
      // lowest zero bit wins
      for (int k = 0; k < NUM_CS; k++) begin
        if (!found && !code_i[k]) begin
          cs_n_o[k] = 1'b0;
          idx_o     = IDX_W'(k);
          found     = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_cs_timer.sv
module spi_cs_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/spi_cs_shreg.sv
module spi_cs_shreg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_i,
  input  logic         sample_i,
  input  logic         miso_i,
  output logic         mosi_o,
  output logic [W-1:0] rx_o
);
  logic [W-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load_i)       tx_q <= data_i;
      else if (shift_i) tx_q <= {tx_q[W-2:0], 1'b0};
      if (sample_i)     rx_q <= {rx_q[W-2:0], miso_i};
    end
  end

  assign mosi_o = tx_q[W-1];
  assign rx_o   = rx_q;
endmodule

// File: rtl/spi_cs_seq.sv
module spi_cs_seq
  import spi_cs_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 4,
  parameter int unsigned DLY_W  = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    decode_en_i,
  input  logic                    fixed_sel_i,
  input  logic [CODE_W-1:0]       fixed_code_i,
  input  logic [NUM_CS*DIV_W-1:0] cfg_div_i,
  input  logic [NUM_CS*DLY_W-1:0] cfg_dly_i,
  input  logic [NUM_CS-1:0]       cfg_hold_i,
  input  logic                    wr_valid_i,
  input  logic [CODE_W-1:0]       wr_code_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic                    miso_i,
  output logic                    tx_empty_o,
  output logic                    sclk_o,
  output logic                    mosi_o,
  output logic [NUM_CS-1:0]       cs_n_o,
  output logic [DATA_W-1:0]       rx_data_o,
  output logic                    rx_done_o
);
  localparam int unsigned BIT_W = $clog2(DATA_W);
  localparam int unsigned CNT_W = (DIV_W + 1 > DLY_W) ? DIV_W + 1 : DLY_W;

  seq_st_e state_q, state_d;

  logic [CODE_W-1:0] eff_code;
  logic [NUM_CS-1:0] w_cs_n;
  logic [IDX_W-1:0]  w_idx;
  logic              w_valid, wr_acc;

  logic              hold_valid_q;
  logic [DATA_W-1:0] hold_data_q;
  logic [NUM_CS-1:0] hold_cs_q, cur_cs_q;
  logic [IDX_W-1:0]  hold_idx_q, cur_idx_q;
  logic              cs_act_q, sclk_q, rx_done_q;
  logic [BIT_W-1:0]  bit_cnt_q;

  logic [DIV_W-1:0]  div_cur, div_hold;
  logic [DLY_W-1:0]  dly_cur;
  logic              same_cs;

  logic              tmr_ld, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;
  logic              do_load, rel, drop, end_decide, xfer_end;
  logic              sclk_d, sh_shift, sh_sample, bit_inc;

  assign eff_code = fixed_sel_i ? fixed_code_i : wr_code_i;

  spi_cs_map i_map (
    .decode_i (decode_en_i),
    .code_i   (eff_code),
    .cs_n_o   (w_cs_n),
    .idx_o    (w_idx),
    .valid_o  (w_valid)
  );

  assign wr_acc   = wr_valid_i && !hold_valid_q && w_valid;
  assign div_cur  = cfg_div_i[cur_idx_q*DIV_W +: DIV_W];
  assign div_hold = cfg_div_i[hold_idx_q*DIV_W +: DIV_W];
  assign dly_cur  = cfg_dly_i[cur_idx_q*DLY_W +: DLY_W];
  assign same_cs  = (hold_cs_q == cur_cs_q);

  spi_cs_timer #(.W(CNT_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_ld),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  spi_cs_shreg #(.W(DATA_W)) i_shreg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (do_load),
    .data_i   (hold_data_q),
    .shift_i  (sh_shift),
    .sample_i (sh_sample),
    .miso_i   (miso_i),
    .mosi_o   (mosi_o),
    .rx_o     (rx_data_o)
  );

  always_comb begin
    state_d    = state_q;
    tmr_ld     = 1'b0;
    tmr_val    = '0;
    do_load    = 1'b0;
    rel        = 1'b0;
    drop       = 1'b0;
    end_decide = 1'b0;
    xfer_end   = 1'b0;
    sclk_d     = sclk_q;
    sh_shift   = 1'b0;
    sh_sample  = 1'b0;
    bit_inc    = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (hold_valid_q) do_load = 1'b1;
      ST_SETUP: if (tmr_zero) begin
        sclk_d    = 1'b1;
        sh_sample = 1'b1;
        tmr_ld    = 1'b1;
        tmr_val   = CNT_W'(div_cur);
        state_d   = ST_SHIFT;
      end
      ST_SHIFT: if (tmr_zero) begin
        tmr_ld  = 1'b1;
        tmr_val = CNT_W'(div_cur);
        sclk_d  = !sclk_q;
        if (!sclk_q)                             sh_sample = 1'b1;
        else if (bit_cnt_q == BIT_W'(DATA_W-1)) xfer_end  = 1'b1;
        else begin
          sh_shift = 1'b1;
          bit_inc  = 1'b1;
        end
      end
      ST_GAP:   if (tmr_zero) end_decide = 1'b1;
      ST_HOLD:  if (hold_valid_q) begin
        if (same_cs) do_load = 1'b1;
        else         rel     = 1'b1;
      end
      ST_REL:   if (tmr_zero) do_load = 1'b1;
      default:  state_d = ST_IDLE;
    endcase

    if (xfer_end) begin
      if (dly_cur != '0) begin
        state_d = ST_GAP;
        tmr_ld  = 1'b1;
        tmr_val = CNT_W'(dly_cur) - CNT_W'(1);
      end else begin
        end_decide = 1'b1;
      end
    end

    if (end_decide) begin
      if (hold_valid_q && same_cs)   do_load = 1'b1;
      else if (hold_valid_q)         rel     = 1'b1;
      else if (cfg_hold_i[cur_idx_q]) state_d = ST_HOLD;
      else begin
        state_d = ST_IDLE;
        drop    = 1'b1;
      end
    end

    // released line stays high one full serial period
    if (rel) begin
      state_d = ST_REL;
      drop    = 1'b1;
      tmr_ld  = 1'b1;
      tmr_val = CNT_W'({div_cur, 1'b1});
    end

    if (do_load) begin
      state_d = ST_SETUP;
      tmr_ld  = 1'b1;
      tmr_val = CNT_W'(div_hold);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      hold_valid_q <= 1'b0;
      hold_data_q  <= '0;
      hold_cs_q    <= '1;
      hold_idx_q   <= '0;
      cur_cs_q     <= '1;
      cur_idx_q    <= '0;
      cs_act_q     <= 1'b0;
      sclk_q       <= 1'b0;
      bit_cnt_q    <= '0;
      rx_done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      sclk_q    <= sclk_d;
      rx_done_q <= xfer_end;
      if (wr_acc) begin
        hold_valid_q <= 1'b1;
        hold_data_q  <= wr_data_i;
        hold_cs_q    <= w_cs_n;
        hold_idx_q   <= w_idx;
      end else if (do_load) begin
        hold_valid_q <= 1'b0;
      end
      if (do_load) begin
        cur_cs_q  <= hold_cs_q;
        cur_idx_q <= hold_idx_q;
        cs_act_q  <= 1'b1;
        bit_cnt_q <= '0;
      end else begin
        if (drop)    cs_act_q  <= 1'b0;
        if (bit_inc) bit_cnt_q <= bit_cnt_q + BIT_W'(1);
      end
    end
  end

  assign tx_empty_o = !hold_valid_q;
  assign sclk_o     = sclk_q;
  assign cs_n_o     = cs_act_q ? cur_cs_q : '1;
  assign rx_done_o  = rx_done_q;
endmodule

// File: rtl/spi_cs_seq_chk.sv
module spi_cs_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       decode_en_i,
  input logic       fixed_sel_i,
  input logic [3:0] fixed_code_i,
  input logic       wr_valid_i,
  input logic [3:0] wr_code_i,
  input logic       tx_empty_o,
  input logic       sclk_o,
  input logic [3:0] cs_n_o
);
  logic [3:0] code_seen;
  assign code_seen = fixed_sel_i ? fixed_code_i : wr_code_i;

  AST_SCLK_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> (cs_n_o != 4'hF)); // R8

  AST_DIRECT_ONE_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!decode_en_i && cs_n_o != 4'hF) |-> ($countones(~cs_n_o) == 1)); // R3

  AST_NO_DIRECT_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_o != 4'hF && $past(cs_n_o) != 4'hF) |-> (cs_n_o == $past(cs_n_o))); // R12

  AST_CS_STABLE_ON_SCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(cs_n_o)); // R9

  AST_IGNORED_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_empty_o && !(wr_valid_i && code_seen != 4'hF)) |=> tx_empty_o); // R4

  AST_EMPTY_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cs_n_o) == 4'hF && cs_n_o != 4'hF) |-> tx_empty_o); // R7
endmodule

bind spi_cs_seq spi_cs_seq_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .decode_en_i  (decode_en_i),
  .fixed_sel_i  (fixed_sel_i),
  .fixed_code_i (fixed_code_i),
  .wr_valid_i   (wr_valid_i),
  .wr_code_i    (wr_code_i),
  .tx_empty_o   (tx_empty_o),
  .sclk_o       (sclk_o),
  .cs_n_o       (cs_n_o)
);

// File: tb/test_spi_cs_seq.sv
module test_spi_cs_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic decode_en = 1'b1, fixed_sel = 1'b0;
  logic [3:0] fixed_code = 4'h0;
  logic [15:0] cfg_div = {4{4'd1}};
  logic [23:0] cfg_dly = {6'd0, 6'd6, 6'd0, 6'd0};
  logic [3:0] cfg_hold = 4'b0010;
  logic wr_valid = 1'b0;
  logic [3:0] wr_code = 4'h0;
  logic [7:0] wr_data = 8'h00;
  logic miso, tx_empty, sclk, mosi, rx_done;
  logic [3:0] cs;
  logic [7:0] rx_data;

  always #10 clk = ~clk;

  spi_cs_seq i_spi_cs_seq (
    .clk_i(clk), .rst_ni(rst_n), .decode_en_i(decode_en), .fixed_sel_i(fixed_sel),
    .fixed_code_i(fixed_code), .cfg_div_i(cfg_div), .cfg_dly_i(cfg_dly),
    .cfg_hold_i(cfg_hold), .wr_valid_i(wr_valid), .wr_code_i(wr_code),
    .wr_data_i(wr_data), .miso_i(miso), .tx_empty_o(tx_empty), .sclk_o(sclk),
    .mosi_o(mosi), .cs_n_o(cs), .rx_data_o(rx_data), .rx_done_o(rx_done)
  );

  // slave model: answers {4'hC, select pattern}
  logic [2:0] sl_cnt;
  logic [7:0] sl_sr, sl_word, reply;
  logic [3:0] sl_cs;
  int sl_n;
  assign reply = {4'hC, cs};
  assign miso  = reply[3'd7 - sl_cnt];

  always @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      sl_cnt <= '0; sl_sr <= '0; sl_word <= '0; sl_cs <= 4'hF; sl_n <= 0;
    end else if (cs != 4'hF) begin
      sl_sr  <= {sl_sr[6:0], mosi};
      sl_cnt <= sl_cnt + 3'd1;
      if (sl_cnt == 3'd7) begin
        sl_word <= {sl_sr[6:0], mosi};
        sl_cs   <= cs;
        sl_n    <= sl_n + 1;
      end
    end
  end

  // line monitor
  logic [3:0] cs_prev = 4'hF;
  int rel_n = 0, idle_run = 0, last_idle = 0, low_run = 0, max_low = 0;
  logic [7:0] last_rx = 8'h00;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_prev != 4'hF && cs == 4'hF) rel_n++;
      if (cs == 4'hF) idle_run++;
      else begin
        if (cs_prev == 4'hF) last_idle = idle_run;
        idle_run = 0;
      end
      if (cs != 4'hF && !sclk) begin
        low_run++;
        if (low_run > max_low) max_low = low_run;
      end else low_run = 0;
      if (rx_done) last_rx = rx_data;
    end
    cs_prev = cs;
  end

  int n_chk = 0, n_err = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] code, input logic [7:0] data);
    while (!tx_empty) @(negedge clk);
    wr_valid = 1'b1; wr_code = code; wr_data = data;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_n(input int target);
    while (sl_n < target) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (cs != 4'hF) @(negedge clk);
  endtask

  // early reload, write-while-full, inter-transfer gap
  task automatic b2b(input logic [3:0] code, input logic [7:0] d1, input logic [7:0] d2,
                     input int exp_gap, input string gap_req);
    int n0, r0;
    n0 = sl_n; r0 = rel_n;
    @(posedge clk); max_low = 0;
    @(negedge clk);
    send(code, d1);
    @(negedge clk);
    chk(tx_empty && cs != 4'hF && sl_n == n0, "R7", {tx_empty, cs}, 5'h10);
    send(code, d2);
    wr_valid = 1'b1; wr_data = 8'h99;  // holding register full
    @(negedge clk);
    wr_valid = 1'b0;
    wait_n(n0 + 2);
    repeat (60) @(negedge clk);
    chk(sl_n == n0 + 2, "R4", sl_n - n0, 2);
    chk(sl_word == d2, "R8", sl_word, d2);
    chk(rel_n == r0 + 1, "R9", rel_n - r0, 1);
    chk(max_low == exp_gap, gap_req, max_low, exp_gap);
  endtask

  // decode, code, data, expected select pattern
  localparam logic [16:0] VEC [8] = '{
    {1'b1, 4'h0, 8'hA5, 4'h0},
    {1'b1, 4'h3, 8'h3C, 4'h3},
    {1'b1, 4'h9, 8'h81, 4'h9},
    {1'b1, 4'hE, 8'h7E, 4'hE},
    {1'b0, 4'hE, 8'h55, 4'hE},
    {1'b0, 4'h4, 8'hF0, 4'hE},
    {1'b0, 4'hB, 8'h0F, 4'hB},
    {1'b0, 4'h7, 8'hC3, 4'h7}
  };

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R8 watchdog: actual hang expected completion");
    finish_run();
  end

  initial begin
    int n0, r0;
    repeat (3) @(negedge clk);
    chk(cs == 4'hF && !sclk && tx_empty, "R1", {cs, sclk, tx_empty}, 6'h3D);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs == 4'hF && !sclk && tx_empty, "R1", {cs, sclk, tx_empty}, 6'h3D);

    for (int i = 0; i < 8; i++) begin
      decode_en = VEC[i][16];
      @(negedge clk);
      n0 = sl_n; r0 = rel_n;
      send(VEC[i][15:12], VEC[i][11:4]);
      wait_n(n0 + 1);
      wait_idle();
      repeat (2) @(negedge clk);
      chk(sl_word == VEC[i][11:4], "R8", sl_word, VEC[i][11:4]);
      if (VEC[i][16]) chk(sl_cs == VEC[i][3:0], "R2", sl_cs, VEC[i][3:0]);
      else            chk(sl_cs == VEC[i][3:0], "R3", sl_cs, VEC[i][3:0]);
      chk(last_rx == {4'hC, VEC[i][3:0]}, "R8", last_rx, {4'hC, VEC[i][3:0]});
      chk(rel_n == r0 + 1, "R10", rel_n - r0, 1);
    end

    // unusable code
    decode_en = 1'b1;
    n0 = sl_n;
    send(4'hF, 8'h11);
    repeat (50) @(negedge clk);
    chk(tx_empty && cs == 4'hF && sl_n == n0, "R4", {tx_empty, cs}, 5'h1F);

    // fixed code source
    fixed_sel = 1'b1; fixed_code = 4'h3;
    n0 = sl_n;
    send(4'h9, 8'h66);
    wait_n(n0 + 1);
    wait_idle();
    chk(sl_cs == 4'h3 && sl_word == 8'h66, "R6", sl_cs, 3);
    fixed_sel = 1'b0;
    @(negedge clk);

    b2b(4'h0, 8'h12, 8'h34, 2, "R13");
    b2b(4'h8, 8'h56, 8'h78, 8, "R13");
    decode_en = 1'b0;
    @(negedge clk);
    b2b(4'hB, 8'h9A, 8'hBC, 8, "R5");
    decode_en = 1'b1;
    @(negedge clk);

    // hold-after-transfer on slot 1
    n0 = sl_n; r0 = rel_n;
    send(4'h5, 8'hE1);
    wait_n(n0 + 1);
    repeat (30) @(negedge clk);
    chk(cs == 4'h5 && !sclk && tx_empty, "R11", cs, 5);
    send(4'h5, 8'hE2);
    wait_n(n0 + 2);
    repeat (30) @(negedge clk);
    chk(rel_n == r0 && cs == 4'h5, "R11", rel_n - r0, 0);
    send(4'h2, 8'hE3);
    wait_n(n0 + 3);
    chk(sl_cs == 4'h2 && sl_word == 8'hE3, "R12", sl_cs, 2);
    chk(last_idle == 4, "R12", last_idle, 4);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(rel_n == r0 + 2, "R10", rel_n - r0, 2);

    // reset mid-transfer
    send(4'h1, 8'hAA);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(cs == 4'hF && !sclk && tx_empty, "R1", {cs, sclk, tx_empty}, 6'h3D);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(cs == 4'hF && !sclk && tx_empty, "R1", {cs, sclk, tx_empty}, 6'h3D);

    finish_run();
  end
endmodule